// File: doc/BRIEF.md
# Content-Directed Pointer Prefetch Scanner

This block looks at every cache line that comes back from memory and picks out the words that look like pointers. It keeps no table of earlier misses. Each aligned 32-bit word in the line is compared with the line's own address. A word whose top twelve bits match the line's top twelve bits is taken to point near the line, and it becomes a prefetch address. Because no history is involved, the scanner can produce addresses that have never been referenced before.

A fill is offered as a single beat that carries the line address and the whole 64-byte line. All sixteen comparisons run in the cycle the line is accepted. The surviving addresses are then handed out one per handshake on a valid/ready output, lowest word first. A new line is refused until the last address of the current line has been taken. Each address is cut down to its line boundary, and a word is dropped when its line address repeats the one from the candidate just before it.

Top module: `cdp_pointer_scanner`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Word i of the line is `in_data[32*i+31 : 32*i]`. A word is a candidate only when its bits [31:20] equal bits [31:20] of `in_addr`. A word that differs in any of bits [31:20] is never emitted, even if it differs in only one bit.
- R3: A word equal to 0x00000000 is never a candidate, even when bits [31:20] of `in_addr` are zero.
- R4: Each emitted `out_addr` is the candidate word with bits [5:0] forced to 0.
- R5: Candidates leave in ascending word index, one per cycle in which `out_valid` and `out_ready` are both 1.
- R6: A candidate is dropped when its aligned address equals the aligned address of the closest lower-index candidate in the same line. Equal addresses that have a different candidate between them are each emitted.
- R7: `in_ready` is 0 from the cycle after a line that yields at least one address is accepted until its last address is taken. It is 1 in the cycle after that last handshake, and a line held on the input is accepted then.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_addr` keeps its value in the next cycle.
- R9: A line with no candidates produces no output, and `in_ready` stays 1.
- R10: For a line that yields at least one address, `out_valid` rises in the cycle after the line is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A line fill is offered |
| in_ready | output | 1 | Scanner can take a line |
| in_addr | input | 32 | Address of the offered line |
| in_data | input | 512 | Line contents, word i in bits 32*i+31 down to 32*i |
| out_valid | output | 1 | A prefetch address is offered |
| out_ready | input | 1 | Consumer takes the prefetch address |
| out_addr | output | 32 | Line-aligned prefetch address |

## Verification
Two things can fall in the same cycle: the handshake that takes the last address of one line, and a next line that is already waiting on the input. The bench provokes this by raising `in_valid` with a second line right after the first line is accepted, and it keeps `in_valid` high while the first line drains under a stalling `out_ready`. It then checks that every address of the first line comes out in order, that `in_ready` stays low until the cycle after the final pop, and that the second line's addresses follow from its own words alone.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

    // Default geometry of the scanner
    localparam int unsigned CDP_PTR_W      = 32;
    localparam int unsigned CDP_LINE_BYTES = 64;
    localparam int unsigned CDP_REGION_LO  = 20;

    // Number of pointer-sized words held in one line
    function automatic int unsigned cdp_words(input int unsigned line_bytes,
                                              input int unsigned ptr_w);
        return (line_bytes * 8) / ptr_w;
    endfunction

    // Width of the byte offset inside a line
    function automatic int unsigned cdp_ofs_w(input int unsigned line_bytes);
        return $clog2(line_bytes);
    endfunction

endpackage

// File: rtl/cdp_word_match.sv
// One word of a fill: decide whether it points into the line's region and
// produce its line-aligned target.
module cdp_word_match #(
    parameter int unsigned PTR_W     = 32,
    parameter int unsigned REGION_LO = 20,
    parameter int unsigned OFS_W     = 6
) (
    input  logic [PTR_W-1:0] word,
    input  logic [PTR_W-1:0] base,
    output logic             hit,
    output logic [PTR_W-1:0] target
);
    localparam logic [PTR_W-1:0] LOW_MASK = PTR_W'((64'(1) << OFS_W) - 64'(1));

    logic [PTR_W-1:0] diff;

    assign diff   = word ^ base;
    assign hit    = ((diff >> REGION_LO) == '0) && (word != '0);
    assign target = word & ~LOW_MASK;
endmodule

// File: rtl/cdp_dup_filter.sv
// Drops a candidate whose target repeats that of the nearest lower candidate.
module cdp_dup_filter #(
    parameter int unsigned WORDS = 16,
    parameter int unsigned PTR_W = 32
) (
    input  logic [WORDS-1:0]            hit,
    input  logic [WORDS-1:0][PTR_W-1:0] target,
    output logic [WORDS-1:0]            keep
);
    // carry_*[i]: most recent candidate among words 0..i
    logic [WORDS-2:0]            carry_v;
    logic [WORDS-2:0][PTR_W-1:0] carry_a;

    assign keep[0]    = hit[0];
    assign carry_v[0] = hit[0];
    assign carry_a[0] = target[0];

    for (genvar i = 1; i < WORDS; i++) begin : g_chain
        assign keep[i] = hit[i] && !(carry_v[i-1] && (target[i] == carry_a[i-1]));
        if (i < WORDS - 1) begin : g_carry
            assign carry_v[i] = carry_v[i-1] | hit[i];
            assign carry_a[i] = hit[i] ? target[i] : carry_a[i-1];
        end
    end
endmodule

// File: rtl/cdp_first_pick.sv
// Selects the lowest pending word and presents its target.
module cdp_first_pick #(
    parameter int unsigned WORDS = 16,
    parameter int unsigned PTR_W = 32
) (
    input  logic [WORDS-1:0]            pending,
    input  logic [WORDS-1:0][PTR_W-1:0] target,
    output logic                        any,
    output logic [WORDS-1:0]            onehot,
    output logic [PTR_W-1:0]            addr
);
    assign any    = |pending;
    assign onehot = pending & (~pending + {{(WORDS-1){1'b0}}, 1'b1});

    always_comb begin
        addr = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (onehot[i]) addr = addr | target[i];
        end
    end
endmodule

// File: rtl/cdp_pointer_scanner.sv
module cdp_pointer_scanner
    import cdp_pkg::*;
#(
    parameter int unsigned ADDR_W     = CDP_PTR_W,
    parameter int unsigned LINE_BYTES = CDP_LINE_BYTES,
    parameter int unsigned REGION_LO  = CDP_REGION_LO,
    localparam int unsigned WORDS     = cdp_words(LINE_BYTES, ADDR_W),
    localparam int unsigned OFS_W     = cdp_ofs_w(LINE_BYTES),
    localparam int unsigned DATA_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr
);
    logic [WORDS-1:0]             hit_c;
    logic [WORDS-1:0]             keep_c;
    logic [WORDS-1:0][ADDR_W-1:0] tgt_c;
    logic [WORDS-1:0]             pend_q;
    logic [WORDS-1:0][ADDR_W-1:0] tgt_q;
    logic [WORDS-1:0]             pick_oh;
    logic                         pick_any;
    logic                         accept;
    logic                         pop;

    // All word comparisons of the offered line, in parallel
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        cdp_word_match #(
            .PTR_W    (ADDR_W),
            .REGION_LO(REGION_LO),
            .OFS_W    (OFS_W)
        ) u_match (
            .word  (in_data[i*ADDR_W +: ADDR_W]),
            .base  (in_addr),
            .hit   (hit_c[i]),
            .target(tgt_c[i])
        );
    end

    cdp_dup_filter #(
        .WORDS(WORDS),
        .PTR_W(ADDR_W)
    ) u_dup (
        .hit   (hit_c),
        .target(tgt_c),
        .keep  (keep_c)
    );

    cdp_first_pick #(
        .WORDS(WORDS),
        .PTR_W(ADDR_W)
    ) u_pick (
        .pending(pend_q),
        .target (tgt_q),
        .any    (pick_any),
        .onehot (pick_oh),
        .addr   (out_addr)
    );

    assign in_ready  = ~|pend_q;
    assign out_valid = pick_any;
    assign accept    = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (accept) begin
            pend_q <= keep_c;
        end else if (pop) begin
            pend_q <= pend_q & ~pick_oh;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) tgt_q <= tgt_c;
    end
endmodule

// File: rtl/cdp_scanner_chk.sv
module cdp_scanner_chk #(
    parameter int unsigned PTR_W     = 32,
    parameter int unsigned REGION_LO = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [PTR_W-1:0] in_addr,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PTR_W-1:0] out_addr
);
    logic [PTR_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else if (in_valid && in_ready) line_q <= in_addr;
    end

    // R8
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

    // R4
    line_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_addr[5:0] == 6'd0));

    // R2
    same_region_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((out_addr ^ line_q) >> REGION_LO) == '0));

    // R10
    first_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R6
    no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> !(out_valid && (out_addr == $past(out_addr))));
endmodule

bind cdp_pointer_scanner cdp_scanner_chk #(
    .PTR_W    (ADDR_W),
    .REGION_LO(REGION_LO)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_addr  (in_addr),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_addr (out_addr)
);

// File: tb/tb_cdp_pointer_scanner.sv
`timescale 1ns/1ps
module tb_cdp_pointer_scanner;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_addr = '0;
    logic [511:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [31:0]  out_addr;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_q [16];
    int          exp_n;
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    cdp_pointer_scanner dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_addr  (in_addr),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_addr (out_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic step_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    // Expected output list, derived from the requirement text
    task automatic build_exp(input logic [31:0] a, input logic [511:0] d);
        logic        have;
        logic [31:0] last;
        have  = 1'b0;
        last  = '0;
        exp_n = 0;
        for (int i = 0; i < 16; i++) begin
            logic [31:0] w;
            logic [31:0] al;
            w  = d[32*i +: 32];
            al = {w[31:6], 6'd0};
            if (w != 32'd0 && w[31:20] == a[31:20]) begin
                if (!(have && al == last)) begin
                    exp_q[exp_n] = al;
                    exp_n++;
                end
                last = al;
                have = 1'b1;
            end
        end
    endtask

    // Offer a line at a negedge; it is taken at the next posedge
    task automatic offer(input logic [31:0] a, input logic [511:0] d);
        @(negedge clk);
        in_addr  = a;
        in_data  = d;
        in_valid = 1'b1;
        chk(in_ready == 1'b1, "R7 idle ready", {31'd0, in_ready}, 32'd1);
        build_exp(a, d);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Drain the current line, starting at the negedge after acceptance
    task automatic drain(input int mode);
        int          idx;
        int          stp;
        bit          was_stall;
        logic [31:0] held;
        idx = 0;
        stp = 0;
        was_stall = 1'b0;
        held = '0;
        if (exp_n > 0)
            chk(out_valid == 1'b1, "R10 first output", {31'd0, out_valid}, 32'd1);
        else
            chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 empty line",
                {30'd0, out_valid, in_ready}, 32'd1);
        while (idx < exp_n) begin
            bit rdy;
            chk(out_valid == 1'b1, "R5 valid while pending", {31'd0, out_valid}, 32'd1);
            chk(out_addr == exp_q[idx], "R5 order/value", out_addr, exp_q[idx]);
            chk(in_ready == 1'b0, "R7 busy", {31'd0, in_ready}, 32'd0);
            if (was_stall)
                chk(out_addr == held, "R8 hold", out_addr, held);
            case (mode)
                0:       rdy = 1'b1;
                1:       rdy = (stp % 2) == 1;
                2:       rdy = (stp % 3) == 2;
                default: begin step_rng(); rdy = rng[3]; end
            endcase
            out_ready = rdy;
            was_stall = !rdy;
            held = out_addr;
            @(posedge clk);
            if (rdy) idx++;
            stp++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R7 line done", {31'd0, out_valid}, 32'd0);
        chk(in_ready == 1'b1, "R7 ready again", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic rand_line(output logic [31:0] a, output logic [511:0] d);
        logic [11:0] h;
        logic [31:0] prev;
        step_rng();
        case (rng[1:0])
            2'd0:    h = 12'h000;
            2'd1:    h = 12'h800;
            default: h = rng[31:20];
        endcase
        step_rng();
        a = {h, rng[19:0]};
        prev = {h, 20'h00100};
        for (int i = 0; i < 16; i++) begin
            logic [31:0] w;
            step_rng();
            case (rng % 6)
                0, 4:    w = {h, rng[23:4]};
                1:       w = {prev[31:6], rng[9:4]};
                2:       w = 32'd0;
                3:       w = {h ^ (rng[15:4] | 12'h001), rng[31:12]};
                default: w = rng;
            endcase
            d[32*i +: 32] = w;
            prev = w;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0]  a;
        logic [511:0] d;
        logic [31:0]  b_addr;
        logic [511:0] b_data;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", {31'd0, out_valid}, 32'd0);
        chk(in_ready == 1'b1, "R1 ready in reset", {31'd0, in_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", {31'd0, out_valid}, 32'd0);
        chk(in_ready == 1'b1, "R1 ready after reset", {31'd0, in_ready}, 32'd1);

        // R3 and R9: all-zero line in the zero region gives nothing
        offer(32'h0000_1000, '0);
        chk(exp_n == 0, "R3 model", exp_n, 0);
        drain(0);

        // R3 with one true low pointer: only 0x40 is emitted, R4 alignment
        d = '0;
        d[32*5 +: 32] = 32'h0000_0047;
        offer(32'h0000_2000, d);
        chk(exp_n == 1 && exp_q[0] == 32'h0000_0040, "R4 model", exp_q[0], 32'h40);
        drain(0);

        // R2 sweep: flip each of the 32 bits of a region address
        for (int half = 0; half < 2; half++) begin
            a = 32'h5A5C_3000;
            for (int k = 0; k < 16; k++)
                d[32*k +: 32] = (32'h5A5C_3000 ^ (32'd1 << (16*half + k))) + 32'(k * 64);
            offer(a, d);
            drain(half + 1);
        end

        // R6: adjacent duplicates collapse, separated duplicates survive
        d = '0;
        d[32*0 +: 32] = 32'h1230_0104;
        d[32*1 +: 32] = 32'h1230_0108;
        d[32*2 +: 32] = 32'h1230_013C;
        d[32*3 +: 32] = 32'hFFFF_0000;
        d[32*4 +: 32] = 32'h1230_0200;
        d[32*5 +: 32] = 32'h1230_0110;
        offer(32'h1234_5640, d);
        chk(exp_n == 3, "R6 model count", exp_n, 3);
        drain(0);

        // R7 overlap: second line held on the input while the first drains
        a = 32'hABC0_0000;
        for (int k = 0; k < 16; k++) d[32*k +: 32] = 32'hABC0_0000 + 32'(k * 128 + 4);
        b_addr = 32'h7770_0040;
        for (int k = 0; k < 16; k++) b_data[32*k +: 32] = (k % 3 == 0) ? 32'h7771_0000 + 32'(k * 64) : 32'h0;
        offer(a, d);
        in_addr  = b_addr;
        in_data  = b_data;
        in_valid = 1'b1;
        drain(2);
        build_exp(b_addr, b_data);
        @(negedge clk);
        in_valid = 1'b0;
        drain(3);

        // R8: long stall pattern
        offer(32'hC000_0000, {16{32'hC00A_BCD4 ^ 32'h0}} ^ {512'h0});
        drain(2);

        // Sweep of mixed lines with varying back-pressure (R5, R6, R7)
        for (int n = 0; n < 400; n++) begin
            rand_line(a, d);
            offer(a, d);
            drain(n % 4);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule